// File: doc/BRIEF.md
# Shared-Memory Load/Store Sequencer

This block steps through a short program held in a 32-word by 16-bit synchronous RAM. The same RAM also serves as data storage. A program counter chooses the next instruction. A single data register is the only place a value can travel from a load to a store. A two-state controller (fetch, access) decides, cycle by cycle, what drives the one RAM address port. The RAM is internal. A synchronous active-low reset reloads it with a fixed image: instructions in words 0x00–0x0F and data in words 0x10–0x1F. The block then runs that program for ever, with the counter wrapping from 31 to 0.

The RAM registers its address on the rising edge, so a word can be read in the cycle after its address was presented. While fetching, the RAM output is the current instruction, and the block decodes it in that cycle. A no-operation instruction takes one cycle and puts the next program address on the port. A load or store puts its own address field on the port instead, and then spends one extra access cycle:

- A store writes the data register at the edge that ends the fetch cycle.
- A load copies the RAM output into the data register at the edge that ends the access cycle.

Every output exists for observation only. The image copies words 0x10–0x13 to 0x18–0x1B and then reads the copies back.

Top module: `ldst_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block enters fetch (`state_o`=0) with `pc_o`=0, `data_reg`=0 and `wr_en`=0, and `rd_word` then shows RAM word 0 (0x00AA in the boot image).
- R2: A fetch cycle whose instruction is neither load nor store lasts one cycle. `access_flag` stays 0, `mem_addr` shows `pc_o`+1, and `pc_o` then advances by one.
- R3: The opcode is bits 15:13 of the instruction, and the word address is bits 4:0. Opcode 5 is a load, opcode 4 is a store, and every other opcode is a no-operation.
- R4: A load or store lasts two cycles: a fetch cycle (`state_o`=0) with `access_flag`=1 and `mem_addr` equal to the address field, then one access cycle (`state_o`=1), after which fetch resumes.
- R5: A store raises `wr_en` for exactly its fetch cycle and writes `data_reg` to the addressed word. `rd_word` shows the newly written value in the following access cycle.
- R6: A load updates `data_reg` with the `rd_word` of its access cycle, at the end of that cycle. `data_reg` changes at no other time.
- R7: In an access cycle, `pc_o` has already advanced past the load/store, and `mem_addr` equals `pc_o`, so the next instruction is fetched without a gap.
- R8: `pc_o` wraps from 31 to 0; after one full pass (44 cycles) word 0 is fetched again.
- R9: Running the boot image leaves words 0x18–0x1B holding 0x0011, 0x0022, 0x0033 and 0x0044, as seen by the loads at image addresses 0x0C–0x0F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset; also reloads the RAM image |
| mem_addr | output | 5 | Address presented to the RAM this cycle |
| pc_o | output | 5 | Program counter |
| rd_word | output | 16 | RAM read word (address latched at the previous edge) |
| data_reg | output | 16 | Data register |
| wr_en | output | 1 | RAM write enable |
| access_flag | output | 1 | High in a fetch cycle that decodes a load or store |
| state_o | output | 1 | Controller state: 0 fetch, 1 access |

## Verification
The boot program is walked cycle by cycle against a vector table covering three patterns. A run of no-operations shows the single-cycle path and the counter-driven address. Alternating load/store pairs show the two-cycle path and separate write-then-read-back from a stale read. Loads of the freshly stored words show that stores went to the field address rather than the program address. Directed steps then follow the counter across the 31-to-0 wrap, and apply reset in the middle of an access cycle while the data register is non-zero.

// File: rtl/ldst_pkg.sv
// Package: shared state type, opcode values and the boot image generator.
// Assumes 16-bit words and a 32-word image; words past 31 boot as zero.
package ldst_pkg;

    typedef enum logic {
        ST_FETCH  = 1'b0,
        ST_ACCESS = 1'b1
    } seq_state_e;

    localparam logic [2:0] OPC_STORE = 3'd4;
    localparam logic [2:0] OPC_LOAD  = 3'd5;

    // Computes the boot content of one RAM word from its index.
    function automatic logic [15:0] boot_word(input int idx);
        logic [15:0] w;
        w = '0;
        if (idx < 4) begin
            w = 16'h00AA + 16'(idx * 17);
        end else if (idx < 12) begin
            if (idx % 2 == 0) w = 16'hA010 + 16'((idx - 4) / 2);
            else              w = 16'h8018 + 16'((idx - 5) / 2);
        end else if (idx < 16) begin
            w = 16'hA018 + 16'(idx - 12);
        end else if (idx < 24) begin
            w = 16'(17 * (idx - 15));
        end else if (idx < 31) begin
            w = 16'h00F1 + 16'(idx - 24);
        end else if (idx == 31) begin
            w = 16'h00D8;
        end
        return w;
    endfunction

endpackage

// File: rtl/ldst_ram.sv
// Single-port synchronous RAM. The address is registered on the rising edge
// and the read word follows the registered address, so a write is visible
// at once. Reset reloads every word from the boot image.
module ldst_ram
    import ldst_pkg::*;
#(
    parameter int AW    = 5,
    parameter int DW    = 16,
    parameter int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] addr_q;

    // Latch the address, perform writes, reload image on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= DW'(boot_word(i));
            end
        end else begin
            addr_q <= addr;
            if (we) begin
                mem[addr] <= wdata;
            end
        end
    end

    // Read word from the registered address.
    assign rdata = mem[addr_q];

endmodule

// File: rtl/ldst_decode.sv
// Instruction decoder: classifies an opcode as load, store or no-operation
// and passes the word-address field through. Purely combinational.
module ldst_decode
    import ldst_pkg::*;
#(
    parameter int AW = 5,
    parameter int OW = 3
) (
    input  logic [OW-1:0] opcode,
    input  logic [AW-1:0] field_in,
    output logic          is_load,
    output logic          is_store,
    output logic          is_mem,
    output logic [AW-1:0] field
);

    // Compare the opcode against the two memory opcodes.
    always_comb begin
        is_load  = (opcode == OW'(OPC_LOAD));
        is_store = (opcode == OW'(OPC_STORE));
        is_mem   = is_load | is_store;
        field    = field_in;
    end

endmodule

// File: rtl/ldst_ctrl.sv
// Two-state controller holding the program counter, the latched load/store
// kind and the data register; also drives the RAM address mux.
// Assumes the RAM output in a fetch cycle is the word at pc.
module ldst_ctrl
    import ldst_pkg::*;
#(
    parameter int AW = 5,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] rd_word,
    input  logic          dec_load,
    input  logic          dec_store,
    input  logic          dec_mem,
    input  logic [AW-1:0] dec_field,
    output seq_state_e    state,
    output logic [AW-1:0] pc,
    output logic [DW-1:0] dreg,
    output logic [AW-1:0] ram_addr,
    output logic          ram_we,
    output logic          mem_flag
);

    logic          pend_load;
    logic [AW-1:0] pc_inc;

    assign pc_inc = pc + 1'b1;

    // Sequence state, counter, load marker and data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_FETCH;
            pc        <= '0;
            pend_load <= 1'b0;
            dreg      <= '0;
        end else begin
            unique case (state)
                ST_FETCH: begin
                    pc <= pc_inc;
                    if (dec_mem) begin
                        pend_load <= dec_load;
                        state     <= ST_ACCESS;
                    end
                end
                ST_ACCESS: begin
                    if (pend_load) begin
                        dreg <= rd_word;
                    end
                    state <= ST_FETCH;
                end
                default: state <= ST_FETCH;
            endcase
        end
    end

    // Choose the RAM address and write strobe for this cycle.
    always_comb begin
        if (state == ST_ACCESS) begin
            ram_addr = pc;
        end else if (dec_mem) begin
            ram_addr = dec_field;
        end else begin
            ram_addr = pc_inc;
        end
        ram_we   = (state == ST_FETCH) && dec_store;
        mem_flag = (state == ST_FETCH) && dec_mem;
    end

endmodule

// File: rtl/ldst_sequencer.sv
// Top: wires the RAM, the decoder and the controller together and exposes
// observation outputs. Assumes a free-running clock; no external bus.
module ldst_sequencer
    import ldst_pkg::*;
#(
    parameter int AW = 5,
    parameter int DW = 16,
    parameter int OW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] pc_o,
    output logic [DW-1:0] rd_word,
    output logic [DW-1:0] data_reg,
    output logic          wr_en,
    output logic          access_flag,
    output logic          state_o
);

    seq_state_e    state;
    logic          dec_load;
    logic          dec_store;
    logic          dec_mem;
    logic [AW-1:0] dec_field;

    ldst_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (mem_addr),
        .we    (wr_en),
        .wdata (data_reg),
        .rdata (rd_word)
    );

    ldst_decode #(.AW(AW), .OW(OW)) u_dec (
        .opcode   (rd_word[DW-1 -: OW]),
        .field_in (rd_word[AW-1:0]),
        .is_load  (dec_load),
        .is_store (dec_store),
        .is_mem   (dec_mem),
        .field    (dec_field)
    );

    ldst_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_word   (rd_word),
        .dec_load  (dec_load),
        .dec_store (dec_store),
        .dec_mem   (dec_mem),
        .dec_field (dec_field),
        .state     (state),
        .pc        (pc_o),
        .dreg      (data_reg),
        .ram_addr  (mem_addr),
        .ram_we    (wr_en),
        .mem_flag  (access_flag)
    );

    assign state_o = (state == ST_ACCESS);

endmodule

// File: rtl/ldst_sequencer_chk.sv
// Checker: temporal properties of the sequencer's observation outputs.
// Bound to every instance of the top module.
module ldst_sequencer_chk #(
    parameter int AW = 5,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] mem_addr,
    input logic [AW-1:0] pc_o,
    input logic [DW-1:0] data_reg,
    input logic          wr_en,
    input logic          access_flag,
    input logic          state_o
);

    // R4: an access cycle is always followed by a fetch cycle.
    a_r4_access_ends: assert property (@(posedge clk) disable iff (!rst_n)
        state_o |=> !state_o);

    // R4: a flagged fetch cycle is followed by an access cycle.
    a_r4_flag_enters_access: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_o && access_flag) |=> state_o);

    // R5: writes happen only in a flagged fetch cycle.
    a_r5_write_in_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (!state_o && access_flag));

    // R2: a plain fetch advances the counter by one.
    a_r2_nop_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_o && !access_flag) |=> (pc_o == AW'($past(pc_o) + 1'b1)));

    // R6: the data register holds across every fetch cycle.
    a_r6_dreg_holds_in_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        !state_o |=> $stable(data_reg));

    // R7: in an access cycle the port shows the counter.
    a_r7_access_addr: assert property (@(posedge clk) disable iff (!rst_n)
        state_o |-> (mem_addr == pc_o));

endmodule

bind ldst_sequencer ldst_sequencer_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_addr    (mem_addr),
    .pc_o        (pc_o),
    .data_reg    (data_reg),
    .wr_en       (wr_en),
    .access_flag (access_flag),
    .state_o     (state_o)
);

// File: tb/ldst_sequencer_tb.sv
// Bench: walks a per-cycle expectation table for the boot program, then
// directed checks for counter wrap and reset during an access cycle.
module ldst_sequencer_tb;

    logic        clk;
    logic        rst_n;
    logic [4:0]  mem_addr;
    logic [4:0]  pc_o;
    logic [15:0] rd_word;
    logic [15:0] data_reg;
    logic        wr_en;
    logic        access_flag;
    logic        state_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    ldst_sequencer u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mem_addr    (mem_addr),
        .pc_o        (pc_o),
        .rd_word     (rd_word),
        .data_reg    (data_reg),
        .wr_en       (wr_en),
        .access_flag (access_flag),
        .state_o     (state_o)
    );

    // 100 MHz clock.
    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Row: {state, pc, addr, we, flag, dreg, rd}
    localparam int ROWS = 29;
    localparam logic [44:0] VEC [ROWS] = '{
        {1'b0, 5'h00, 5'h01, 1'b0, 1'b0, 16'h0000, 16'h00AA},
        {1'b0, 5'h01, 5'h02, 1'b0, 1'b0, 16'h0000, 16'h00BB},
        {1'b0, 5'h02, 5'h03, 1'b0, 1'b0, 16'h0000, 16'h00CC},
        {1'b0, 5'h03, 5'h04, 1'b0, 1'b0, 16'h0000, 16'h00DD},
        {1'b0, 5'h04, 5'h10, 1'b0, 1'b1, 16'h0000, 16'hA010},
        {1'b1, 5'h05, 5'h05, 1'b0, 1'b0, 16'h0000, 16'h0011},
        {1'b0, 5'h05, 5'h18, 1'b1, 1'b1, 16'h0011, 16'h8018},
        {1'b1, 5'h06, 5'h06, 1'b0, 1'b0, 16'h0011, 16'h0011},
        {1'b0, 5'h06, 5'h11, 1'b0, 1'b1, 16'h0011, 16'hA011},
        {1'b1, 5'h07, 5'h07, 1'b0, 1'b0, 16'h0011, 16'h0022},
        {1'b0, 5'h07, 5'h19, 1'b1, 1'b1, 16'h0022, 16'h8019},
        {1'b1, 5'h08, 5'h08, 1'b0, 1'b0, 16'h0022, 16'h0022},
        {1'b0, 5'h08, 5'h12, 1'b0, 1'b1, 16'h0022, 16'hA012},
        {1'b1, 5'h09, 5'h09, 1'b0, 1'b0, 16'h0022, 16'h0033},
        {1'b0, 5'h09, 5'h1A, 1'b1, 1'b1, 16'h0033, 16'h801A},
        {1'b1, 5'h0A, 5'h0A, 1'b0, 1'b0, 16'h0033, 16'h0033},
        {1'b0, 5'h0A, 5'h13, 1'b0, 1'b1, 16'h0033, 16'hA013},
        {1'b1, 5'h0B, 5'h0B, 1'b0, 1'b0, 16'h0033, 16'h0044},
        {1'b0, 5'h0B, 5'h1B, 1'b1, 1'b1, 16'h0044, 16'h801B},
        {1'b1, 5'h0C, 5'h0C, 1'b0, 1'b0, 16'h0044, 16'h0044},
        {1'b0, 5'h0C, 5'h18, 1'b0, 1'b1, 16'h0044, 16'hA018},
        {1'b1, 5'h0D, 5'h0D, 1'b0, 1'b0, 16'h0044, 16'h0011},
        {1'b0, 5'h0D, 5'h19, 1'b0, 1'b1, 16'h0011, 16'hA019},
        {1'b1, 5'h0E, 5'h0E, 1'b0, 1'b0, 16'h0011, 16'h0022},
        {1'b0, 5'h0E, 5'h1A, 1'b0, 1'b1, 16'h0022, 16'hA01A},
        {1'b1, 5'h0F, 5'h0F, 1'b0, 1'b0, 16'h0022, 16'h0033},
        {1'b0, 5'h0F, 5'h1B, 1'b0, 1'b1, 16'h0033, 16'hA01B},
        {1'b1, 5'h10, 5'h10, 1'b0, 1'b0, 16'h0033, 16'h0044},
        {1'b0, 5'h10, 5'h11, 1'b0, 1'b0, 16'h0044, 16'h0011}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic next_cycle();
        @(negedge clk);
        #1;
    endtask

    // Compare every observed output against one table row.
    task automatic check_row(input int k);
        logic [44:0] v;
        v = VEC[k];
        check("R4", $sformatf("cyc%0d state", k), 32'(state_o), 32'(v[44]));
        check("R2", $sformatf("cyc%0d pc", k), 32'(pc_o), 32'(v[43:39]));
        check(v[44] ? "R7" : "R3", $sformatf("cyc%0d addr", k),
              32'(mem_addr), 32'(v[38:34]));
        check("R5", $sformatf("cyc%0d we", k), 32'(wr_en), 32'(v[33]));
        check("R4", $sformatf("cyc%0d flag", k), 32'(access_flag), 32'(v[32]));
        check("R6", $sformatf("cyc%0d dreg", k), 32'(data_reg), 32'(v[31:16]));
        check((k >= 21 && k <= 27) ? "R9" : "R5", $sformatf("cyc%0d rd", k),
              32'(rd_word), 32'(v[15:0]));
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: state right after reset.
        check("R1", "reset state", 32'(state_o), 32'd0);
        check("R1", "reset pc", 32'(pc_o), 32'd0);
        check("R1", "reset dreg", 32'(data_reg), 32'd0);
        check("R1", "reset rd", 32'(rd_word), 32'h00AA);
        check_row(0);
        for (int k = 1; k < ROWS; k++) begin
            next_cycle();
            check_row(k);
        end
        // R8: 16 data no-operations, then wrap to word 0 at cycle 44.
        for (int k = ROWS; k <= 44; k++) begin
            next_cycle();
        end
        check("R8", "wrap pc", 32'(pc_o), 32'd0);
        check("R8", "wrap rd", 32'(rd_word), 32'h00AA);
        check("R8", "wrap dreg", 32'(data_reg), 32'h0044);
        for (int k = 45; k <= 49; k++) begin
            next_cycle();
        end
        check("R4", "second pass access", 32'(state_o), 32'd1);
        // R1: reset in the middle of an access cycle.
        rst_n = 1'b0;
        next_cycle();
        check("R1", "mid reset state", 32'(state_o), 32'd0);
        check("R1", "mid reset pc", 32'(pc_o), 32'd0);
        check("R1", "mid reset dreg", 32'(data_reg), 32'd0);
        check("R1", "mid reset we", 32'(wr_en), 32'd0);
        check("R1", "mid reset rd", 32'(rd_word), 32'h00AA);
        rst_n = 1'b1;
        next_cycle();
        check("R2", "restart pc", 32'(pc_o), 32'd1);
        check("R2", "restart rd", 32'(rd_word), 32'h00BB);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule